// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block gathers a set of level-sensitive hardware request lines and a smaller set of request sources that software raises and lowers by register writes. Each source carries a run-time programmable 4-bit level. Every cycle the block picks the strongest pending source and presents it to the CPU as a registered request, along with its vector number and level. The request goes out only when the winning level is strictly above the level the CPU is currently running at.

Nesting is handled in hardware. The CPU claims an interrupt by reading the claim register. That read returns the vector, saves the running level on an internal level stack, and raises the running level to the level of the claimed source. A later, stronger request therefore preempts the handler, while equal and weaker requests wait. Writing the completion register restores the saved level. Software can also overwrite the running level directly, for example to lift itself to a ceiling level around a shared resource.

Software sources let a handler split its work. The urgent part runs at a high level and then raises a software source at a lower level for the rest of the work.

Top module: `prio_intc`

## Requirements
- R1: After reset, irq_o is low, the running level reads 0, every source level reads 0 and no software source is pending.
- R2: irq_o is high exactly when a pending source has a nonzero level strictly above the running level; a source at level 0 never requests.
- R3: The winner is the pending source with the highest level, and a tie goes to the lowest source number. irq_vec_o is the source number: hardware line k is source k, and software source j is source N_HW+j. irq_prio_o is the winner's level.
- R4: irq_o, irq_vec_o and irq_prio_o are registered. A change on hw_req_i shows at the outputs after exactly one rising clock edge.
- R5: The level of source i is read and written at register address i, using data bits [3:0]. Upper data bits are ignored.
- R6: A write to address N_SRC+3 sets software source j for each set data bit j. A write to N_SRC+4 clears them. Reading N_SRC+3 returns the software pending bits.
- R7: A read of the claim address N_SRC+1 while irq_o is high and the stack is not full returns bit 31 set and the vector in bits [VEC_W-1:0]. In the same cycle it pushes the running level and sets the running level to irq_prio_o. In any other case the read returns 0 and changes nothing.
- R8: A write to the completion address N_SRC+2 pops the stack into the running level. On an empty stack it has no effect.
- R9: The running level is read and written at address N_SRC, data bits [3:0], and it masks requests at or below its value.
- R10: The level stack holds 16 entries. A claim while it is full is refused as described in R7.
- R11: While a handler runs at level p, a new request above p raises irq_o, and a request at level p does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req_i | input | N_HW | Level-sensitive hardware request lines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (a claim read has side effects) |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, combinational from address and state |
| irq_o | output | 1 | Registered request to the CPU |
| irq_vec_o | output | VEC_W | Vector of the presented request |
| irq_prio_o | output | 4 | Level of the presented request |

## Verification
A change on a request line reaches irq_o after one rising edge. A register write updates state at its own edge, and the arbitration result reflects that state one edge later. The bench therefore drives on falling edges and waits two full idle cycles after each operation before comparing the outputs with its reference model. Claim read data is combinational, so it is sampled shortly after the read strobe rises, before the edge that commits the push. The latency check itself samples once before and once just after the single edge.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int PRIO_W = 4;
  localparam int LEVELS = 1 << PRIO_W;

  // register kinds, offset above the per-source level registers
  typedef enum logic [2:0] {
    RK_CUR   = 3'd0,
    RK_CLAIM = 3'd1,
    RK_DONE  = 3'd2,
    RK_SWSET = 3'd3,
    RK_SWCLR = 3'd4
  } reg_kind_e;

  localparam int NUM_KINDS = 5;
endpackage

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int N_SRC = 12,
  parameter int VEC_W = 4
) (
  input  logic [N_SRC-1:0]        pend_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  output logic                    win_valid_o,
  output logic [VEC_W-1:0]        win_vec_o,
  output logic [PRIO_W-1:0]       win_prio_o
);
  logic [PRIO_W-1:0] best_p;
  logic [VEC_W-1:0]  best_v;

  // strict compare: a later source only wins on a higher level, so ties
  // resolve to the lowest number and level 0 can never be selected
  always_comb begin
    best_p = '0;
    best_v = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (pend_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > best_p)) begin
        best_p = prio_i[i*PRIO_W +: PRIO_W];
        best_v = VEC_W'(i);
      end
    end
  end

  assign win_valid_o = (best_p != '0);
  assign win_vec_o   = best_v;
  assign win_prio_o  = best_p;
endmodule

// File: rtl/intc_prio_stack.sv
module intc_prio_stack #(
  parameter int DEPTH = 16,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_data_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] top_idx;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign top_idx = cnt_q - 1'b1;
  assign top_o   = empty_o ? '0 : mem_q[top_idx[PTR_W-1:0]];

  always_comb begin
    cnt_d = cnt_q;
    if (push_i && !full_o)      cnt_d = cnt_q + 1'b1;
    else if (pop_i && !empty_o) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // data storage needs no reset: it is only read below the count
  always_ff @(posedge clk) begin
    if (push_i && !full_o) mem_q[cnt_q[PTR_W-1:0]] <= push_data_i;
  end

  // R10: the controller never asks for a push beyond the depth
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && full_o));

  // R8: a pop on an empty stack is filtered before it reaches here
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_i && empty_o));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int N_HW        = 8,
  parameter int N_SW        = 4,
  parameter int STACK_DEPTH = 16,
  parameter int DATA_W      = 32,
  localparam int N_SRC      = N_HW + N_SW,
  localparam int VEC_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int ADDR_W     = $clog2(N_SRC + NUM_KINDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_HW-1:0]   hw_req_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  output logic [PRIO_W-1:0] irq_prio_o
);
  localparam logic [ADDR_W-1:0] A_CUR   = ADDR_W'(N_SRC + int'(RK_CUR));
  localparam logic [ADDR_W-1:0] A_CLAIM = ADDR_W'(N_SRC + int'(RK_CLAIM));
  localparam logic [ADDR_W-1:0] A_DONE  = ADDR_W'(N_SRC + int'(RK_DONE));
  localparam logic [ADDR_W-1:0] A_SWSET = ADDR_W'(N_SRC + int'(RK_SWSET));
  localparam logic [ADDR_W-1:0] A_SWCLR = ADDR_W'(N_SRC + int'(RK_SWCLR));

  logic [PRIO_W-1:0]       prio_q [N_SRC];
  logic [N_SRC*PRIO_W-1:0] prio_flat;
  logic [N_SW-1:0]         sw_pend_q, sw_pend_d;
  logic [PRIO_W-1:0]       cur_q, cur_d;
  logic                    irq_q, irq_d;
  logic [VEC_W-1:0]        vec_q, vec_d;
  logic [PRIO_W-1:0]       ip_q, ip_d;
  logic [N_SRC-1:0]        pend;
  logic                    win_valid;
  logic [VEC_W-1:0]        win_vec;
  logic [PRIO_W-1:0]       win_prio;
  logic                    stk_empty, stk_full;
  logic [PRIO_W-1:0]       stk_top;
  logic                    claim_ok, done_ok, cur_we, swset_we, swclr_we;

  assign pend = {sw_pend_q, hw_req_i};

  // per-source level registers
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic lvl_we;
    assign lvl_we = reg_wr_i && (reg_addr_i == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      prio_q[g] <= '0;
      else if (lvl_we) prio_q[g] <= reg_wdata_i[PRIO_W-1:0];
    end
    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
  end

  intc_arbiter #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_arb (
    .pend_i      (pend),
    .prio_i      (prio_flat),
    .win_valid_o (win_valid),
    .win_vec_o   (win_vec),
    .win_prio_o  (win_prio)
  );

  // register port decode
  assign claim_ok = reg_rd_i && (reg_addr_i == A_CLAIM) && irq_q && !stk_full;
  assign done_ok  = reg_wr_i && (reg_addr_i == A_DONE) && !stk_empty;
  assign cur_we   = reg_wr_i && (reg_addr_i == A_CUR);
  assign swset_we = reg_wr_i && (reg_addr_i == A_SWSET);
  assign swclr_we = reg_wr_i && (reg_addr_i == A_SWCLR);

  intc_prio_stack #(.DEPTH(STACK_DEPTH), .W(PRIO_W)) u_stk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (claim_ok),
    .pop_i       (done_ok),
    .push_data_i (cur_q),
    .top_o       (stk_top),
    .empty_o     (stk_empty),
    .full_o      (stk_full)
  );

  // next state
  always_comb begin
    cur_d = cur_q;
    if (claim_ok)     cur_d = ip_q;
    else if (done_ok) cur_d = stk_top;
    else if (cur_we)  cur_d = reg_wdata_i[PRIO_W-1:0];

    sw_pend_d = sw_pend_q;
    if (swset_we)      sw_pend_d = sw_pend_q | reg_wdata_i[N_SW-1:0];
    else if (swclr_we) sw_pend_d = sw_pend_q & ~reg_wdata_i[N_SW-1:0];

    // compare against the level that will hold after this edge
    irq_d = win_valid && (win_prio > cur_d);
    vec_d = irq_d ? win_vec : '0;
    ip_d  = irq_d ? win_prio : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q     <= '0;
      sw_pend_q <= '0;
      irq_q     <= 1'b0;
      vec_q     <= '0;
      ip_q      <= '0;
    end else begin
      cur_q     <= cur_d;
      sw_pend_q <= sw_pend_d;
      irq_q     <= irq_d;
      vec_q     <= vec_d;
      ip_q      <= ip_d;
    end
  end

  // read data
  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (reg_addr_i == ADDR_W'(i)) reg_rdata_o = DATA_W'(prio_q[i]);
    end
    if (reg_addr_i == A_CUR)   reg_rdata_o = DATA_W'(cur_q);
    if (reg_addr_i == A_SWSET) reg_rdata_o = DATA_W'(sw_pend_q);
    if (reg_addr_i == A_CLAIM && irq_q && !stk_full) begin
      reg_rdata_o[DATA_W-1]  = 1'b1;
      reg_rdata_o[VEC_W-1:0] = vec_q;
    end
  end

  assign irq_o      = irq_q;
  assign irq_vec_o  = vec_q;
  assign irq_prio_o = ip_q;

  // R2: a presented request always sits above the running level
  p_above_cur_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_prio_o > cur_q));

  // R7: a claim raises the running level to the claimed level
  p_claim_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    claim_ok |=> (cur_q == $past(ip_q)));

  // R8: completion restores the saved level
  p_done_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> (cur_q == $past(stk_top)));

  // R6: cleared software sources are no longer pending
  p_swclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    swclr_we |=> ((sw_pend_q & $past(reg_wdata_i[N_SW-1:0])) == '0));
endmodule

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
  localparam int CLK_P  = 10;
  localparam int N_HW   = 8;
  localparam int N_SW   = 4;
  localparam int N_SRC  = N_HW + N_SW;
  localparam int VEC_W  = $clog2(N_SRC);
  localparam int ADDR_W = $clog2(N_SRC + 5);
  localparam int A_CUR = N_SRC, A_CLAIM = N_SRC + 1, A_DONE = N_SRC + 2;
  localparam int A_SWSET = N_SRC + 3, A_SWCLR = N_SRC + 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N_HW-1:0]   hw_req = '0;
  logic              wr = 1'b0, rd = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              irq;
  logic [VEC_W-1:0]  vec;
  logic [3:0]        iprio;

  int errors = 0, checks = 0;
  int mprio [N_SRC];
  int mstk  [16];
  int mdepth = 0, mcur = 0;
  logic [N_SW-1:0] msw = '0;

  always #(CLK_P/2) clk = ~clk;

  prio_intc #(.N_HW(N_HW), .N_SW(N_SW)) u_prio_intc (
    .clk(clk), .rst_n(rst_n), .hw_req_i(hw_req), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .irq_vec_o(vec), .irq_prio_o(iprio));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_win(output bit v, output int w, output int p);
    int best = 0;
    w = 0;
    for (int i = 0; i < N_SRC; i++) begin
      bit pd = (i < N_HW) ? hw_req[i] : msw[i-N_HW];
      if (pd && mprio[i] > best) begin best = mprio[i]; w = i; end
    end
    p = best;
    v = (best > mcur);
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input int a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(input int a, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; addr = ADDR_W'(a);
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic do_write_prio(input int s, input logic [31:0] d);
    reg_write(s, d);
    mprio[s] = int'(d[3:0]);
  endtask

  task automatic do_claim(input string req);
    bit v; int w, p; logic [31:0] d, exp;
    model_win(v, w, p);
    exp = '0;
    if (v && mdepth < 16) begin exp[31] = 1'b1; exp[VEC_W-1:0] = VEC_W'(w); end
    reg_read(A_CLAIM, d);
    chk(d == exp, req, int'(d), int'(exp));
    if (exp[31]) begin mstk[mdepth] = mcur; mdepth++; mcur = p; end
    idle(2);
  endtask

  task automatic do_done();
    reg_write(A_DONE, 32'h0);
    if (mdepth > 0) begin mdepth--; mcur = mstk[mdepth]; end
    idle(2);
  endtask

  task automatic do_cur(input int c);
    reg_write(A_CUR, 32'(c));
    mcur = c;
    idle(2);
  endtask

  task automatic check_state(input string tag);
    bit v; int w, p; logic [31:0] d;
    model_win(v, w, p);
    chk(irq == v, {"R2 irq ", tag}, int'(irq), int'(v));
    if (v) begin
      chk(int'(vec) == w, {"R3 vector ", tag}, int'(vec), w);
      chk(int'(iprio) == p, {"R3 level ", tag}, int'(iprio), p);
    end
    reg_read(A_CUR, d);
    chk(int'(d) == mcur, {"R9 running level ", tag}, int'(d), mcur);
    reg_read(A_SWSET, d);
    chk(d[N_SW-1:0] == msw, {"R6 sw pending ", tag}, int'(d), int'(msw));
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    foreach (mprio[i]) mprio[i] = 0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1: reset state
    chk(irq == 1'b0, "R1 irq after reset", int'(irq), 0);
    for (int i = 0; i < N_SRC; i++) begin
      reg_read(i, d);
      chk(d == 0, "R1 level after reset", int'(d), 0);
    end
    check_state("reset R1");

    // R2: level 0 never requests
    hw_req[2] = 1'b1;
    idle(2);
    chk(irq == 1'b0, "R2 level zero", int'(irq), 0);

    // R5: upper data bits ignored
    do_write_prio(2, 32'hFFFF_FFA5);
    reg_read(2, d);
    chk(d == 32'h5, "R5 level readback", int'(d), 5);
    idle(1);
    check_state("R5");

    // R4: exactly one edge of latency from a request line
    do_write_prio(6, 32'd9);
    idle(2);
    @(negedge clk);
    hw_req[6] = 1'b1;
    #1 chk(int'(vec) == 2, "R4 before edge", int'(vec), 2);
    @(negedge clk);
    chk(int'(vec) == 6, "R4 after one edge", int'(vec), 6);

    // R3: tie goes to the lowest number
    do_write_prio(4, 32'd9);
    hw_req[4] = 1'b1;
    idle(2);
    chk(int'(vec) == 4, "R3 tie lowest", int'(vec), 4);

    // R11: preemption above running level, not at it
    do_claim("R7 claim");
    check_state("R11 running 9");
    reg_write(A_SWSET, 32'h2); msw = 4'h2;
    do_write_prio(N_HW + 1, 32'd9);
    idle(2);
    chk(irq == 1'b0, "R11 equal level held", int'(irq), 0);
    do_write_prio(N_HW + 1, 32'd12);
    idle(2);
    chk(irq == 1'b1 && int'(vec) == N_HW + 1, "R11 preempt", int'(vec), N_HW + 1);
    do_claim("R7 nested claim");
    do_done();
    check_state("R8 pop");
    reg_write(A_SWCLR, 32'h2); msw = 4'h0;
    do_done();
    check_state("R8 pop to 0");
    do_done();
    check_state("R8 empty pop");

    // R10: fill the stack, the 17th claim is refused
    do_write_prio(0, 32'd15);
    hw_req[0] = 1'b1;
    for (int k = 0; k < 17; k++) begin
      do_claim("R10 fill");
      do_cur(0);
    end
    chk(mdepth == 16, "R10 model depth", mdepth, 16);
    for (int k = 0; k < 17; k++) do_done();
    check_state("R10 drained");

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 7);
      case (op)
        0: begin
          int s = $urandom_range(0, N_SRC - 1);
          do_write_prio(s, $urandom);
          idle(2);
        end
        1: begin hw_req = N_HW'($urandom & $urandom); idle(2); end
        2: begin d = $urandom; reg_write(A_SWSET, d); msw = msw | d[N_SW-1:0]; idle(2); end
        3: begin d = $urandom; reg_write(A_SWCLR, d); msw = msw & ~d[N_SW-1:0]; idle(2); end
        4, 5: do_claim("R7 random claim");
        6: do_done();
        default: do_cur($urandom_range(0, 8));
      endcase
      check_state("random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule